// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block holds the per-line state of a small interrupt controller and picks the line that the single CPU interface should service next. The number of lines is a parameter, up to 1020. Each line has an enable bit, a pending bit, an active bit, an 8-bit priority and a trigger type. Software reaches all of this through a 32-bit register bus. Enable and pending use separate write-one-to-set and write-one-to-clear pages. Priorities are stored one byte per line. Trigger types are packed two bits per line.

Lines 0 to 15 are software-generated lines. They have no hardware input and are always edge-triggered. They become pending through the pending-set page or through a dedicated soft-interrupt register. Lines from 16 upward take a hardware input (`hw_irq[n]` drives line n), and each can be configured as level or edge. When forwarding is switched on, the winning line is offered on a registered CPU port. The winner is the enabled, pending, not-active line with the lowest priority value. The CPU acknowledges the offered line, which marks it active, and later ends it by ID.

Top module: `idist_top`

## Requirements
- R1: A write to the enable-set page (byte address 0x100 + 4k) enables line 32k+n for each 1 in bit n. A write to the enable-clear page (0x180 + 4k) disables those lines. Writing 0 bits changes nothing. A read of either page returns the current enable bits of lines 32k..32k+31.
- R2: The pending-set page (0x200 + 4k) and the pending-clear page (0x280 + 4k) use the same bit mapping for pending state. A read of either page returns the current pending bits.
- R3: The priority of line n is the byte at address 0x400 + n, so each word holds four lines with the lowest line in byte 0. A write changes only the bytes whose strobe in `bus_be` is 1.
- R4: The trigger configuration of line n is held in the word at 0x800 + 4*(n/16), bits 2*(n%16) and 2*(n%16)+1. The odd bit selects edge (1) or level (0), and the even bit always reads 0. The word at 0x800 is read-only and always reads 0xAAAAAAAA.
- R5: The type register at 0x004 reads W-1 in bits 4:0, where W = ceil(lines/32). All other bits read 0.
- R6: Bit 0 of the control register at 0x000 enables forwarding and resets to 0. While it is 0, `cpu_irq_valid` stays low.
- R7: A write to the soft-interrupt register at 0x008 sets line `wdata[3:0]` pending in either of two cases: the filter field `wdata[25:24]` is 2'b00 and bit 16 (CPU 0 in the list `wdata[23:16]`) is 1, or the filter field is 2'b10 (self). Filter values 2'b01 and 2'b11 have no effect.
- R8: Acknowledging the offered line (`cpu_ack` while `cpu_irq_valid` is high) sets its active bit and clears its latched pending bit. A write of 1s to the active-clear page (0x300 + 4k, which reads back active bits) clears active bits, and so does `cpu_eoi` with `cpu_eoi_id`.
- R9: Among lines that are enabled, pending and not active, the lowest priority value is offered, and ties go to the lowest line number. `cpu_irq_prio` carries the winner's priority.
- R10: A level line reads as pending for as long as its input is high. An edge line latches pending on a rising input and stays pending after the input falls, until it is cleared or acknowledged.
- R11: Writes that address lines at or beyond the implemented count are ignored, and reads of those lines return 0.
- R12: Read data appears on `bus_rdata` one clock after the read. The CPU port is registered: it drops `cpu_irq_valid` in the cycle after an acknowledge and then shows the next winner. After reset all state is zero, lines 16 and above are level, and `cpu_irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes for writes |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| hw_irq | input | NUM_LINES-16 | Hardware inputs for lines 16..NUM_LINES-1 |
| cpu_irq_valid | output | 1 | A line is offered to the CPU |
| cpu_irq_id | output | 10 | Offered line number |
| cpu_irq_prio | output | 8 | Offered line priority |
| cpu_ack | input | 1 | Acknowledge the offered line |
| cpu_eoi | input | 1 | End of service for `cpu_eoi_id` |
| cpu_eoi_id | input | 10 | Line whose active bit is cleared |

## Verification
The assertions check the cycle-level rules on every cycle:
- the forwarding gate;
- the range of the offered line number;
- the drop of `cpu_irq_valid` after an acknowledge;
- the type and read-only configuration words;
- zero reads from unimplemented enable words.

The arbitration outcome can only be shown by the bench's scenarios. These cover priority order, the tie-break by line number, exclusion of active lines, and the difference between level and latched edge pending. The bench scenarios also cover byte-strobed priority writes and the soft-interrupt filter values.

// File: rtl/idist_pkg.sv
package idist_pkg;
  localparam int unsigned MAX_LINES = 1020;
  localparam int unsigned ID_W      = 10;

  // single-word registers
  localparam logic [11:0] OFS_CTRL = 12'h000;
  localparam logic [11:0] OFS_TYPE = 12'h004;
  localparam logic [11:0] OFS_SOFT = 12'h008;

  // 128-byte pages selected by addr[11:7]
  localparam logic [4:0] PG_SET_EN  = 5'd2;
  localparam logic [4:0] PG_CLR_EN  = 5'd3;
  localparam logic [4:0] PG_SET_PD  = 5'd4;
  localparam logic [4:0] PG_CLR_PD  = 5'd5;
  localparam logic [4:0] PG_CLR_ACT = 5'd6;

  // priority bytes: addr[11:10]; trigger words: addr[11:8]
  localparam logic [1:0] PG_PRIO = 2'b01;
  localparam logic [3:0] PG_CFG  = 4'h8;

  typedef logic [7:0] prio_t;

  typedef enum logic [1:0] {
    TF_LIST   = 2'b00,
    TF_OTHERS = 2'b01,
    TF_SELF   = 2'b10,
    TF_RSVD   = 2'b11
  } tgt_filt_e;
endpackage

// File: rtl/idist_lines.sv
module idist_lines
  import idist_pkg::*;
#(
  parameter int unsigned NUM_LINES = 48
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [11:0]            addr,
  input  logic [31:0]            wdata,
  input  logic [3:0]             be,
  input  logic                   soft_fire,
  input  logic [3:0]             soft_id,
  input  logic [NUM_LINES-1:16]  hw_irq,
  input  logic                   ack_fire,
  input  logic [ID_W-1:0]        ack_id,
  input  logic                   eoi_fire,
  input  logic [ID_W-1:0]        eoi_id,
  output logic [NUM_LINES-1:0]   en_o,
  output logic [NUM_LINES-1:0]   pend_o,
  output logic [NUM_LINES-1:0]   act_o,
  output logic [NUM_LINES-1:0]   edge_o,
  output logic [NUM_LINES*8-1:0] prio_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int unsigned WRD = i / 32;
    localparam int unsigned BT  = i % 32;
    localparam int unsigned PWD = i / 4;
    localparam int unsigned PBY = i % 4;
    localparam int unsigned CWD = i / 16;
    localparam int unsigned CBT = (i % 16) * 2;

    logic  bit_hit, set_en, clr_en, set_pd, clr_pd, clr_act;
    logic  ack_me, eoi_me, soft_me, pr_we, rise, lvl, edg_w;
    logic  en_q, en_d, pd_q, pd_d, act_q, act_d;
    prio_t pr_q, pr_d;

    assign bit_hit = (addr[6:2] == 5'(WRD)) && wdata[BT];
    assign set_en  = wr_en && (addr[11:7] == PG_SET_EN)  && bit_hit;
    assign clr_en  = wr_en && (addr[11:7] == PG_CLR_EN)  && bit_hit;
    assign set_pd  = wr_en && (addr[11:7] == PG_SET_PD)  && bit_hit;
    assign clr_pd  = wr_en && (addr[11:7] == PG_CLR_PD)  && bit_hit;
    assign clr_act = wr_en && (addr[11:7] == PG_CLR_ACT) && bit_hit;
    assign ack_me  = ack_fire && (ack_id == ID_W'(i));
    assign eoi_me  = eoi_fire && (eoi_id == ID_W'(i));
    assign soft_me = soft_fire && ({6'b0, soft_id} == ID_W'(i));
    assign pr_we   = wr_en && (addr[11:10] == PG_PRIO) &&
                     (addr[9:2] == 8'(PWD)) && be[PBY];

    if (i < 16) begin : g_soft
      // software lines: no input pin, fixed edge behaviour
      assign edg_w = 1'b1;
      assign rise  = 1'b0;
      assign lvl   = 1'b0;
    end else begin : g_hw
      logic edg_q, edg_d, in_q, cfg_we;
      assign cfg_we = wr_en && (addr[11:8] == PG_CFG) &&
                      (addr[7:2] == 6'(CWD)) && be[CBT/8];
      assign edg_d  = cfg_we ? wdata[CBT+1] : edg_q;
      assign rise   = edg_q && hw_irq[i] && !in_q;
      assign lvl    = !edg_q && hw_irq[i];
      assign edg_w  = edg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          edg_q <= 1'b0;
          in_q  <= 1'b0;
        end else begin
          if (cfg_we) edg_q <= edg_d;
          in_q <= hw_irq[i];
        end
      end
    end

    always_comb begin
      en_d = en_q;
      if (set_en)      en_d = 1'b1;
      else if (clr_en) en_d = 1'b0;
      pd_d = pd_q;
      if (clr_pd || ack_me)           pd_d = 1'b0;
      if (set_pd || soft_me || rise)  pd_d = 1'b1;
      act_d = act_q;
      if (clr_act || eoi_me) act_d = 1'b0;
      if (ack_me)            act_d = 1'b1;
      pr_d = pr_we ? wdata[PBY*8 +: 8] : pr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q  <= 1'b0;
        pd_q  <= 1'b0;
        act_q <= 1'b0;
        pr_q  <= '0;
      end else begin
        en_q  <= en_d;
        pd_q  <= pd_d;
        act_q <= act_d;
        if (pr_we) pr_q <= pr_d;
      end
    end

    assign en_o[i]          = en_q;
    assign pend_o[i]        = pd_q | lvl;
    assign act_o[i]         = act_q;
    assign edge_o[i]        = edg_w;
    assign prio_o[i*8 +: 8] = pr_q;
  end
endmodule

// File: rtl/idist_arb.sv
module idist_arb
  import idist_pkg::*;
#(
  parameter int unsigned NUM_LINES = 48
) (
  input  logic [NUM_LINES-1:0]   cand,
  input  logic [NUM_LINES*8-1:0] prio_flat,
  output logic                   found,
  output logic [ID_W-1:0]        win_id,
  output prio_t                  win_prio
);
  // ascending scan with strict compare: ties keep the lower line
  always_comb begin
    found    = 1'b0;
    win_id   = '0;
    win_prio = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cand[i] && (!found || (prio_flat[i*8 +: 8] < win_prio))) begin
        found    = 1'b1;
        win_id   = ID_W'(i);
        win_prio = prio_flat[i*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/idist_top.sv
module idist_top
  import idist_pkg::*;
#(
  parameter int unsigned NUM_LINES = 48
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [11:0]           bus_addr,
  input  logic [31:0]           bus_wdata,
  input  logic [3:0]            bus_be,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_LINES-1:16] hw_irq,
  output logic                  cpu_irq_valid,
  output logic [ID_W-1:0]       cpu_irq_id,
  output logic [7:0]            cpu_irq_prio,
  input  logic                  cpu_ack,
  input  logic                  cpu_eoi,
  input  logic [ID_W-1:0]       cpu_eoi_id
);
  localparam int unsigned NWORDS = (NUM_LINES + 31) / 32;

  // reset: asserted asynchronously, released on the clock
  logic rs1, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1   <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rs1   <= 1'b1;
      rst_s <= rs1;
    end
  end

  logic wr_en, rd_en, fwd_q, fwd_d, fwd_we, soft_fire, ack_fire;
  tgt_filt_e filt;
  assign wr_en  = bus_sel && bus_wr;
  assign rd_en  = bus_sel && !bus_wr;
  assign fwd_we = wr_en && (bus_addr == OFS_CTRL) && bus_be[0];
  assign fwd_d  = bus_wdata[0];
  assign filt   = tgt_filt_e'(bus_wdata[25:24]);
  assign soft_fire = wr_en && (bus_addr == OFS_SOFT) &&
                     (((filt == TF_LIST) && bus_wdata[16]) || (filt == TF_SELF));
  assign ack_fire = cpu_ack && cpu_irq_valid;

  logic [NUM_LINES-1:0]   en_v, pd_v, act_v, edge_v;
  logic [NUM_LINES*8-1:0] prio_v;

  idist_lines #(.NUM_LINES(NUM_LINES)) u_lines (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .be(bus_be), .soft_fire(soft_fire),
    .soft_id(bus_wdata[3:0]), .hw_irq(hw_irq), .ack_fire(ack_fire),
    .ack_id(cpu_irq_id), .eoi_fire(cpu_eoi), .eoi_id(cpu_eoi_id),
    .en_o(en_v), .pend_o(pd_v), .act_o(act_v), .edge_o(edge_v), .prio_o(prio_v)
  );

  logic            found;
  logic [ID_W-1:0] win_id;
  prio_t           win_prio;

  idist_arb #(.NUM_LINES(NUM_LINES)) u_arb (
    .cand(en_v & pd_v & ~act_v), .prio_flat(prio_v),
    .found(found), .win_id(win_id), .win_prio(win_prio)
  );

  // registered CPU port; an acknowledge blanks it for one cycle
  logic vld_d;
  assign vld_d = fwd_q && found && !ack_fire;

  // read path: zero-extended views make absent lines read 0
  logic [1023:0] en_pad, pd_pad, act_pad;
  logic [8191:0] pr_pad;
  logic [2047:0] cfg_pad;
  logic [2*NUM_LINES-1:0] cfg_flat;
  logic [31:0] rd_word;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      cfg_flat[2*i]   = 1'b0;
      cfg_flat[2*i+1] = edge_v[i];
    end
  end

  assign en_pad  = 1024'(en_v);
  assign pd_pad  = 1024'(pd_v);
  assign act_pad = 1024'(act_v);
  assign pr_pad  = 8192'(prio_v);
  assign cfg_pad = 2048'(cfg_flat);

  always_comb begin
    rd_word = '0;
    if (bus_addr == OFS_CTRL)      rd_word = {31'b0, fwd_q};
    else if (bus_addr == OFS_TYPE) rd_word = {27'b0, 5'(NWORDS - 1)};
    else if ((bus_addr[11:7] == PG_SET_EN) || (bus_addr[11:7] == PG_CLR_EN))
      rd_word = en_pad[{bus_addr[6:2], 5'b0} +: 32];
    else if ((bus_addr[11:7] == PG_SET_PD) || (bus_addr[11:7] == PG_CLR_PD))
      rd_word = pd_pad[{bus_addr[6:2], 5'b0} +: 32];
    else if (bus_addr[11:7] == PG_CLR_ACT)
      rd_word = act_pad[{bus_addr[6:2], 5'b0} +: 32];
    else if (bus_addr[11:10] == PG_PRIO)
      rd_word = pr_pad[{bus_addr[9:2], 5'b0} +: 32];
    else if (bus_addr[11:8] == PG_CFG)
      rd_word = cfg_pad[{bus_addr[7:2], 5'b0} +: 32];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      fwd_q         <= 1'b0;
      bus_rdata     <= '0;
      cpu_irq_valid <= 1'b0;
      cpu_irq_id    <= '0;
      cpu_irq_prio  <= '0;
    end else begin
      if (fwd_we) fwd_q     <= fwd_d;
      if (rd_en)  bus_rdata <= rd_word;
      cpu_irq_valid <= vld_d;
      cpu_irq_id    <= win_id;
      cpu_irq_prio  <= win_prio;
    end
  end

  logic unused_addr;
  assign unused_addr = ^bus_addr[1:0];
endmodule

// File: rtl/idist_chk.sv
module idist_chk
  import idist_pkg::*;
#(
  parameter int unsigned NUM_LINES = 48
) (
  input logic            clk,
  input logic            rst_s,
  input logic            fwd_q,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [11:0]     bus_addr,
  input logic [31:0]     bus_rdata,
  input logic            cpu_ack,
  input logic            cpu_irq_valid,
  input logic [ID_W-1:0] cpu_irq_id
);
  localparam int unsigned NWORDS = (NUM_LINES + 31) / 32;

  // R6
  fwd_gate_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !fwd_q |=> !cpu_irq_valid);

  // R9
  id_range_chk: assert property (@(posedge clk) disable iff (!rst_s)
    cpu_irq_valid |-> (32'(cpu_irq_id) < NUM_LINES));

  // R12
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (cpu_ack && cpu_irq_valid) |=> !cpu_irq_valid);

  // R5
  type_read_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_sel && !bus_wr && (bus_addr == OFS_TYPE)) |=> (bus_rdata == 32'(NWORDS - 1)));

  // R4
  soft_cfg_read_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_sel && !bus_wr && (bus_addr == 12'h800)) |=> (bus_rdata == 32'hAAAA_AAAA));

  // R11
  absent_word_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_sel && !bus_wr && (bus_addr[11:7] == PG_SET_EN) &&
     (32'(bus_addr[6:2]) >= NWORDS)) |=> (bus_rdata == 32'h0));
endmodule

bind idist_top idist_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_s(rst_s), .fwd_q(fwd_q), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .cpu_ack(cpu_ack),
  .cpu_irq_valid(cpu_irq_valid), .cpu_irq_id(cpu_irq_id)
);

// File: tb/tb_idist_top.sv
module tb_idist_top;
  localparam int unsigned NL = 48;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  bus_be;
  logic [NL-1:16] hw_irq;
  logic        cpu_irq_valid, cpu_ack, cpu_eoi;
  logic [9:0]  cpu_irq_id, cpu_eoi_id;
  logic [7:0]  cpu_irq_prio;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  idist_top #(.NUM_LINES(NL)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .hw_irq(hw_irq), .cpu_irq_valid(cpu_irq_valid),
    .cpu_irq_id(cpu_irq_id), .cpu_irq_prio(cpu_irq_prio), .cpu_ack(cpu_ack),
    .cpu_eoi(cpu_eoi), .cpu_eoi_id(cpu_eoi_id)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 12'h000, 32'h0,         4'hF, 32'h0,         8'd6},  // R6 reset value
    '{1'b0, 12'h004, 32'h0,         4'hF, 32'h1,         8'd5},  // R5 two words
    '{1'b1, 12'h100, 32'h5,         4'hF, 32'h0,         8'd1},
    '{1'b0, 12'h100, 32'h0,         4'hF, 32'h5,         8'd1},  // R1
    '{1'b1, 12'h180, 32'h4,         4'hF, 32'h0,         8'd1},
    '{1'b0, 12'h100, 32'h0,         4'hF, 32'h1,         8'd1},  // R1
    '{1'b0, 12'h180, 32'h0,         4'hF, 32'h1,         8'd1},  // R1 clear page reads
    '{1'b1, 12'h104, 32'hFFFF_FFFF, 4'hF, 32'h0,         8'd11},
    '{1'b0, 12'h104, 32'h0,         4'hF, 32'h0000_FFFF, 8'd11}, // R11
    '{1'b1, 12'h108, 32'hFFFF_FFFF, 4'hF, 32'h0,         8'd11},
    '{1'b0, 12'h108, 32'h0,         4'hF, 32'h0,         8'd11}, // R11
    '{1'b1, 12'h400, 32'h1122_3344, 4'h5, 32'h0,         8'd3},
    '{1'b0, 12'h400, 32'h0,         4'hF, 32'h0022_0044, 8'd3},  // R3
    '{1'b0, 12'h800, 32'h0,         4'hF, 32'hAAAA_AAAA, 8'd4},  // R4
    '{1'b1, 12'h800, 32'h0,         4'hF, 32'h0,         8'd4},
    '{1'b0, 12'h800, 32'h0,         4'hF, 32'hAAAA_AAAA, 8'd4},  // R4 read-only
    '{1'b1, 12'h804, 32'h0000_000A, 4'hF, 32'h0,         8'd4},
    '{1'b0, 12'h804, 32'h0,         4'hF, 32'h0000_000A, 8'd4},  // R4
    '{1'b1, 12'h200, 32'h100,       4'hF, 32'h0,         8'd2},
    '{1'b0, 12'h200, 32'h0,         4'hF, 32'h100,       8'd2},  // R2
    '{1'b1, 12'h280, 32'h100,       4'hF, 32'h0,         8'd2},
    '{1'b0, 12'h200, 32'h0,         4'hF, 32'h0,         8'd2},  // R2
    '{1'b1, 12'h008, 32'h0001_0003, 4'hF, 32'h0,         8'd7},
    '{1'b0, 12'h200, 32'h0,         4'hF, 32'h8,         8'd7},  // R7 list
    '{1'b1, 12'h280, 32'h8,         4'hF, 32'h0,         8'd7},
    '{1'b1, 12'h008, 32'h0101_0005, 4'hF, 32'h0,         8'd7},
    '{1'b0, 12'h200, 32'h0,         4'hF, 32'h0,         8'd7},  // R7 others
    '{1'b1, 12'h008, 32'h0200_0006, 4'hF, 32'h0,         8'd7},
    '{1'b0, 12'h200, 32'h0,         4'hF, 32'h40,        8'd7},  // R7 self
    '{1'b1, 12'h280, 32'h40,        4'hF, 32'h0,         8'd7},
    '{1'b1, 12'h008, 32'h0000_0007, 4'hF, 32'h0,         8'd7},
    '{1'b0, 12'h200, 32'h0,         4'hF, 32'h0,         8'd7},  // R7 empty list
    '{1'b1, 12'h104, 32'h0,         4'hF, 32'h0,         8'd1},
    '{1'b0, 12'h104, 32'h0,         4'hF, 32'h0000_FFFF, 8'd1}   // R1 zeros ignored
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = b;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; bus_be = '0; hw_irq = '0; cpu_ack = 1'b0;
    cpu_eoi = 1'b0; cpu_eoi_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(12, 32'(cpu_irq_valid), 32'h0);  // R12 reset state

    for (int t = 0; t < NV; t++) begin
      if (TBL[t].wr) wr(TBL[t].addr, TBL[t].data, TBL[t].be);
      else           rd(int'(TBL[t].req), TBL[t].addr, TBL[t].exp);
    end

    // clear all enables, then program priorities
    wr(12'h180, 32'hFFFF_FFFF, 4'hF);
    wr(12'h184, 32'hFFFF_FFFF, 4'hF);
    rd(1, 12'h104, 32'h0);                       // R1
    wr(12'h404, 32'h0000_4000, 4'b0010);         // line 5 -> 0x40
    wr(12'h408, 32'h0000_2000, 4'b0010);         // line 9 -> 0x20
    wr(12'h414, 32'h0000_0020, 4'b0001);         // line 20 -> 0x20
    wr(12'h410, 32'h0000_0010, 4'b0001);         // line 16 -> 0x10
    rd(3, 12'h404, 32'h0000_4000);               // R3
    wr(12'h100, (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 16) | (32'h1 << 20), 4'hF);
    wr(12'h200, (32'h1 << 5) | (32'h1 << 9), 4'hF);
    settle();
    chk(6, 32'(cpu_irq_valid), 32'h0);           // R6 gate closed

    wr(12'h000, 32'h1, 4'hF);
    settle();
    chk(6, 32'(cpu_irq_valid), 32'h1);           // R6
    chk(9, 32'(cpu_irq_id), 32'd9);              // R9 lowest value wins
    chk(9, 32'(cpu_irq_prio), 32'h20);

    @(negedge clk); hw_irq[20] = 1'b1;
    settle();
    chk(9, 32'(cpu_irq_id), 32'd9);              // R9 tie -> lower line
    rd(10, 12'h200, (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 20)); // R10 level

    ack();
    chk(12, 32'(cpu_irq_valid), 32'h0);          // R12 blank after ack
    @(negedge clk);
    chk(8, 32'(cpu_irq_id), 32'd20);             // R8 active line skipped
    rd(8, 12'h300, 32'h1 << 9);                  // R8

    ack();
    @(negedge clk);
    chk(9, 32'(cpu_irq_id), 32'd5);              // R9
    @(negedge clk); hw_irq[20] = 1'b0;
    rd(10, 12'h200, 32'h1 << 5);                 // R10 level drops

    @(negedge clk); hw_irq[16] = 1'b1;
    @(negedge clk); hw_irq[16] = 1'b0;
    rd(10, 12'h200, (32'h1 << 5) | (32'h1 << 16)); // R10 edge latched
    settle();
    chk(10, 32'(cpu_irq_id), 32'd16);
    chk(9, 32'(cpu_irq_prio), 32'h10);

    wr(12'h300, 32'h1 << 9, 4'hF);
    rd(8, 12'h300, 32'h1 << 20);                 // R8 clear-active page
    @(negedge clk); cpu_eoi = 1'b1; cpu_eoi_id = 10'd20;
    @(negedge clk); cpu_eoi = 1'b0;
    rd(8, 12'h300, 32'h0);                       // R8 end of service

    wr(12'h000, 32'h0, 4'hF);
    settle();
    chk(6, 32'(cpu_irq_valid), 32'h0);           // R6

    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(12, 12'h100, 32'h0);                      // R12 reset clears state
    rd(12, 12'h804, 32'h0);                      // R12 lines level after reset
    chk(12, 32'(cpu_irq_valid), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule